// File: doc/BRIEF.md
# Dual-Channel Sample Capture with Interleave Demultiplexer

This block sits in front of a pair of 8-bit converter cores and turns incoming sample words into a time-aligned pair of codes, one per channel. It works in one of two capture modes. In parallel mode each channel has its own 8-bit input bus, and both buses are registered on the rising edge of the conversion clock. In interleaved mode only the channel A bus is used. The channel B word is presented during the high half of the clock and taken on the falling edge. The channel A word follows in the low half and is taken on the next rising edge. Interleaving halves the per-channel sample rate (for example 82.5 Msps per channel on a 165 MHz bus rather than 165 Msps), but it needs only one bus.

Captured words pass through an output register, so the cores always see the pair captured on the previous rising edge. Both channels change on the same rising edge, so a mixed pair never appears. A small state machine records which capture mode was in force for the last pair. The states are `ST_IDLE` (first edge after reset), `ST_PAR` (parallel) and `ST_ILV` (interleaved). The transitions are: `ST_IDLE` to `ST_PAR` or `ST_ILV` on the first rising edge after reset, following the mode input; `ST_PAR` to `ST_ILV` when the mode input is high at a rising edge; and `ST_ILV` to `ST_PAR` when it is low. A pair is valid only when it was captured in the same mode as the pair before it. The first pair after reset and the first pair after any mode switch are therefore flagged not valid.

Top module: `dual_dac_capture`

## Requirements
- R1: With `ilv_mode` low at a rising edge, `bus_a` and `bus_b` (8 bits each, bit 7 the MSB) are both captured on that edge.
- R2: A pair captured on rising edge N appears on `code_a`/`code_b` just after rising edge N+1 and holds until edge N+2. This is one cycle of latency.
- R3: With `ilv_mode` high at a rising edge, `code_b` of that pair is the `bus_a` value taken on the preceding falling edge, and `code_a` is the `bus_a` value taken on the rising edge itself.
- R4: `code_a` and `code_b` change only on rising edges and always together. A falling-edge capture does not alter the outputs.
- R5: While `ilv_mode` is high, the value on `bus_b` has no effect on either output.
- R6: The mode is sampled at each rising edge, and every rising edge is a pair boundary. A pair captured in a different mode from the pair before it comes out with `out_valid` low. A pair captured in the same mode as the pair before it comes out with `out_valid` high.
- R7: While `rst_n` is low at a rising edge, the outputs are cleared to code 0 and `out_valid` is cleared to 0. The first pair captured after reset is released is flagged not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; both edges are used |
| rst_n | input | 1 | Active-low synchronous reset |
| ilv_mode | input | 1 | 1 = interleaved capture on `bus_a`, 0 = parallel capture |
| bus_a | input | 8 | Channel A word, or both channels in interleaved mode |
| bus_b | input | 8 | Channel B word in parallel mode, ignored in interleaved mode |
| code_a | output | 8 | Registered channel A code to the converter core |
| code_b | output | 8 | Registered channel B code to the converter core |
| out_valid | output | 1 | The present pair was captured in a settled mode |

## Verification
A wrong mode state shows on `out_valid` exactly two rising edges after the offending capture. The affected pairs are the one right after a switch or after reset, which would be wrongly marked valid, or a steady-mode pair that would be wrongly dropped. A fault in the falling-edge holding register shows as a wrong `code_b` two rising edges after the affected half-cycle. A channel B value that is swapped with, or taken from, a neighbouring sample gives a clear mismatch because each pair carries distinct values. An output that moves on the falling edge is caught in the same cycle by sampling just after that edge and comparing against the value seen after the rising edge.

// File: rtl/dac_cap_pkg.sv
package dac_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PAR  = 2'd1,
        ST_ILV  = 2'd2
    } cap_state_e;
endpackage

// File: rtl/dac_neg_hold.sv
// Falling-edge holding register for the channel B word of an interleaved pair.
module dac_neg_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_ff @(negedge clk) begin
        if (!rst_n) dout <= '0;
        else        dout <= din;
    end
endmodule

// File: rtl/dac_cap_fsm.sv
// Rising-edge capture stage and mode-tracking state machine.
module dac_cap_fsm
    import dac_cap_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ilv_mode,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    input  logic [DW-1:0] hold_b,
    output logic [DW-1:0] cap_a,
    output logic [DW-1:0] cap_b,
    output logic          cap_vld
);
    cap_state_e st, st_nxt;
    logic       pair_ok;

    always_comb begin
        st_nxt  = st;
        pair_ok = 1'b0;
        unique case (st)
            ST_IDLE: begin
                st_nxt  = ilv_mode ? ST_ILV : ST_PAR;
                pair_ok = 1'b0;
            end
            ST_PAR: begin
                st_nxt  = ilv_mode ? ST_ILV : ST_PAR;
                pair_ok = !ilv_mode;
            end
            ST_ILV: begin
                st_nxt  = ilv_mode ? ST_ILV : ST_PAR;
                pair_ok = ilv_mode;
            end
            default: begin
                st_nxt  = ST_IDLE;
                pair_ok = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a   <= '0;
            cap_b   <= '0;
            cap_vld <= 1'b0;
        end else begin
            cap_a   <= bus_a;
            cap_b   <= ilv_mode ? hold_b : bus_b;
            cap_vld <= pair_ok;
        end
    end

    // R7: a capture taken in the idle state is never marked valid
    p_idle_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> !cap_vld);

    // R6: the state after each edge follows the sampled mode
    p_state_follows_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ilv_mode |=> (st == ST_ILV));
endmodule

// File: rtl/dac_out_stage.sv
// Output alignment register shared by all channels.
module dac_out_stage #(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCH-1:0][DW-1:0]  din,
    input  logic                    vld_in,
    output logic [NCH-1:0][DW-1:0]  dout,
    output logic                    vld_out
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            vld_out <= 1'b0;
        end else begin
            for (int c = 0; c < NCH; c++) dout[c] <= din[c];
            vld_out <= vld_in;
        end
    end
endmodule

// File: rtl/dual_dac_capture.sv
module dual_dac_capture #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ilv_mode,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    output logic [DW-1:0] code_a,
    output logic [DW-1:0] code_b,
    output logic          out_valid
);
    localparam int NCH = 2;

    logic [DW-1:0]          hold_b;
    logic [DW-1:0]          cap_a, cap_b;
    logic                   cap_vld;
    logic [NCH-1:0][DW-1:0] cap_pair, out_pair;

    dac_neg_hold #(.DW(DW)) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_a),
        .dout (hold_b)
    );

    dac_cap_fsm #(.DW(DW)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .ilv_mode(ilv_mode),
        .bus_a   (bus_a),
        .bus_b   (bus_b),
        .hold_b  (hold_b),
        .cap_a   (cap_a),
        .cap_b   (cap_b),
        .cap_vld (cap_vld)
    );

    assign cap_pair[0] = cap_a;
    assign cap_pair[1] = cap_b;

    dac_out_stage #(.NCH(NCH), .DW(DW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (cap_pair),
        .vld_in (cap_vld),
        .dout   (out_pair),
        .vld_out(out_valid)
    );

    assign code_a = out_pair[0];
    assign code_b = out_pair[1];

    // Checker: rising edges since reset release, saturating
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    p_par_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && !$past(ilv_mode, 2)) |->
        (code_a == $past(bus_a, 2) && code_b == $past(bus_b, 2)));

    p_ilv_a_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && $past(ilv_mode, 2)) |-> (code_a == $past(bus_a, 2)));

    p_switch_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(ilv_mode, 2) != $past(ilv_mode, 3)) |-> !out_valid);

    p_steady_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(ilv_mode, 2) == $past(ilv_mode, 3)) |-> out_valid);

    p_reset_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd0) |-> (code_a == '0 && code_b == '0 && !out_valid));

    p_first_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd1) |-> !out_valid);
endmodule

// File: tb/dual_dac_capture_test.sv
`timescale 1ns/1ps
module dual_dac_capture_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ilv_mode = 1'b0;
    logic [7:0] bus_a = 8'h00;
    logic [7:0] bus_b = 8'h00;
    logic [7:0] code_a, code_b;
    logic       out_valid;

    int checks = 0;
    int errors = 0;

    // expected pipeline: entry 1 = last driven pair, entry 2 = the one before
    logic [7:0] e1_a, e1_b, e2_a, e2_b;
    logic       e1_v, e2_v, e1_k, e2_k;
    logic       prev_mode;

    dual_dac_capture uut (
        .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode),
        .bus_a(bus_a), .bus_b(bus_b),
        .code_a(code_a), .code_b(code_b), .out_valid(out_valid)
    );

    always #5 clk = ~clk;

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock period: check the pair due now, then drive the next pair.
    task automatic step(input logic m, input logic [7:0] a, input logic [7:0] b, input string req);
        logic [7:0] sa, sb;
        @(posedge clk); #3;
        chk1({req, " valid"}, out_valid, e2_v);
        if (e2_k) begin
            chk8({req, " code_a"}, code_a, e2_a);
            chk8({req, " code_b"}, code_b, e2_b);
        end
        sa = code_a; sb = code_b;
        e2_a = e1_a; e2_b = e1_b; e2_v = e1_v; e2_k = e1_k;
        e1_a = a; e1_b = b; e1_v = (m == prev_mode); e1_k = e1_v;
        prev_mode = m;
        ilv_mode = m;
        if (m) begin
            bus_a = b;
            bus_b = ~a ^ 8'h5A;          // junk, must be ignored (R5)
            @(negedge clk); #1;
            // R4: falling-edge capture leaves outputs untouched
            chk8("R4 code_a steady at falling edge", code_a, sa);
            chk8("R4 code_b steady at falling edge", code_b, sb);
            bus_a = a;
        end else begin
            bus_a = a;
            bus_b = b;
        end
    endtask

    task automatic t_reset(input logic m);
        @(posedge clk); #3;
        rst_n = 1'b0; bus_a = 8'h00; bus_b = 8'h00; ilv_mode = m;
        @(posedge clk); #3;
        chk8("R7 reset clears code_a", code_a, 8'h00);
        chk8("R7 reset clears code_b", code_b, 8'h00);
        chk1("R7 reset clears valid", out_valid, 1'b0);
        repeat (2) @(posedge clk);
        #3 rst_n = 1'b1;
        prev_mode = m;
        // output reset value, then the idle-edge capture of zero buses (R7)
        e2_a = 8'h00; e2_b = 8'h00; e2_v = 1'b0; e2_k = 1'b1;
        e1_a = 8'h00; e1_b = 8'h00; e1_v = 1'b0; e1_k = 1'b1;
    endtask

    task automatic t_parallel();
        step(1'b0, 8'h12, 8'h34, "R1 R2 parallel");
        step(1'b0, 8'hFF, 8'h00, "R1 R2 parallel");
        step(1'b0, 8'h80, 8'h01, "R1 R2 parallel msb/lsb");
        step(1'b0, 8'h00, 8'hFF, "R1 R2 parallel");
        step(1'b0, 8'hA5, 8'h5A, "R1 R2 parallel");
        step(1'b0, 8'h3C, 8'hC3, "R1 R2 parallel");
    endtask

    task automatic t_interleave();
        step(1'b1, 8'h11, 8'h22, "R3 R5 interleave");
        step(1'b1, 8'h33, 8'h44, "R3 R5 interleave");
        step(1'b1, 8'hFE, 8'h01, "R3 R5 interleave");
        step(1'b1, 8'h7F, 8'h80, "R3 R5 interleave");
        step(1'b1, 8'hC0, 8'h0C, "R3 R5 interleave");
    endtask

    task automatic t_switch();
        step(1'b0, 8'h21, 8'h43, "R6 switch to parallel");
        step(1'b0, 8'h65, 8'h87, "R6 settled parallel");
        step(1'b0, 8'hA9, 8'hCB, "R6 settled parallel");
        step(1'b1, 8'hED, 8'h0F, "R6 switch to interleave");
        step(1'b1, 8'h98, 8'h76, "R6 settled interleave");
        step(1'b0, 8'h54, 8'h32, "R6 switch to parallel");
        step(1'b1, 8'h10, 8'h20, "R6 switch to interleave");
        step(1'b1, 8'h30, 8'h40, "R6 settled interleave");
    endtask

    task automatic t_drain(input logic m);
        step(m, 8'h00, 8'h00, "R2 drain");
        step(m, 8'h00, 8'h00, "R2 drain");
    endtask

    logic done = 1'b0;

    initial begin
        t_reset(1'b0);
        t_parallel();
        t_interleave();
        t_switch();
        t_drain(1'b1);
        t_reset(1'b1);          // mid-stream reset in interleave mode (R7)
        t_interleave();
        t_parallel();
        t_drain(1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule